// File: doc/BRIEF.md
# I2C Controller Byte-Queue Interrupt and Status Unit

This unit sits between the host side of an I2C controller and its protocol engine. It owns two byte queues: the transmit queue, filled by the host and drained by the engine, and the receive queue, filled by the engine and drained by the host. It keeps a fill level for each queue and turns those levels, together with misuse of the queues and a transfer-event pulse from the engine, into a set of sticky interrupt status bits and one interrupt line.

Software programs four small registers through a single write port selected by `wr_sel_i`. The registers are queue control, interrupt enables, the interrupt status (write 1 to clear) and the idle count for the trailing-data interrupt. The status word and a queue-status word are always visible on output ports. The trailing-data interrupt covers the tail of a read: when fewer bytes than the receive trigger level sit in the receive queue and no new byte arrives for the programmed number of cycles, software is told to collect them. The queue depth is a build parameter, and both 16 and 64 entries are supported.

Top module: `i2c_fifo_irq_unit`

## Requirements
- R1: After reset, `int_status_o` is 0 and `irq_o` is 0. `queue_status_o` is 0x0100_0100, meaning both queues are empty with level 0. Both queues are disabled, all enables are 0 and the idle count is 0.
- R2: A write with `wr_sel_i`=0 loads queue control. Bit 0 enables the receive queue and bit 1 enables the transmit queue. The receive trigger level is held in bits starting at bit 4, and the transmit trigger level in bits starting at bit 16, each clog2(DEPTH+1) bits wide. A disabled queue is emptied on the next clock edge. Pushes to it and pops from it have no effect and raise no error bit.
- R3: Each queue returns bytes in first-in, first-out order on `tx_data_o`/`rx_data_o`, which show the head entry. The `queue_status_o` fields are: transmit level [6:0], transmit full at bit 7, transmit empty at bit 8, receive level [22:16], receive full at bit 23 and receive empty at bit 24. These fields follow a push or pop one cycle after it.
- R4: Status bit 0 (transmit almost-empty) is set one cycle after a cycle in which the transmit queue is enabled and its level is at or below the transmit trigger.
- R5: Status bit 1 (receive almost-full) is set one cycle after a cycle in which the receive queue is enabled and its level is at or above the receive trigger.
- R6: The following are set one cycle after the offending request: transmit underrun (bit 2) for a pop of an empty transmit queue, transmit overrun (bit 3) for a push to a full transmit queue, receive underrun (bit 4) for a pop of an empty receive queue, and receive overrun (bit 5) for a push to a full receive queue. A rejected push leaves the queue unchanged.
- R7: Status bit 6 (trailing) is defined by an idle counter that is cleared by a receive push or whenever the receive level is 0 or at least the trigger, and otherwise counts up to the idle count. Bit 6 is set one cycle after a cycle in which the level is between 1 and trigger-1, no byte is pushed, and the counter equals the idle count. The idle count is loaded with `wr_sel_i`=3 from bits [3:0].
- R8: Status bit 9 (transfer event) is set one cycle after `xfer_evt_i` is high.
- R9: A write with `wr_sel_i`=2 clears every status bit that is 1 in the data. A bit that is set in the same cycle stays 1, and a bit whose condition still holds is set again one cycle later.
- R10: `irq_o` is high whenever any status bit is 1 and enabled. Enables are written with `wr_sel_i`=1 at bit positions 0, 1, 6 and 9. Bits 2 to 5 are always enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 queue control, 1 enables, 2 status clear, 3 idle count |
| wr_data_i | input | 32 | Register write data |
| tx_push_i | input | 1 | Host pushes a byte into the transmit queue |
| tx_data_i | input | 8 | Byte pushed into the transmit queue |
| tx_pop_i | input | 1 | Engine takes the transmit head byte |
| tx_data_o | output | 8 | Transmit queue head byte |
| rx_push_i | input | 1 | Engine pushes a received byte |
| rx_data_i | input | 8 | Byte pushed into the receive queue |
| rx_pop_i | input | 1 | Host takes the receive head byte |
| rx_data_o | output | 8 | Receive queue head byte |
| xfer_evt_i | input | 1 | Transfer event pulse from the protocol engine |
| int_status_o | output | 32 | Sticky interrupt status |
| queue_status_o | output | 32 | Queue levels and full/empty flags |
| irq_o | output | 1 | Interrupt line |

## Verification
Queue levels, the full/empty flags and the head bytes change at the clock edge that accepts a push or pop, so they are correct in the cycle just after the request. Every status bit is registered from the levels and requests of the cycle before the edge, and so appears exactly one cycle after its cause. The trailing bit fires idle-count+1 edges after the last receive push. `irq_o` follows the status and enables with no further delay. The bench drives inputs at the falling edge, updates its reference model at the rising edge from the inputs of the cycle before, and compares every output at the following falling edge. Directed checks are placed at the cycles these latencies predict.

// File: rtl/i2c_fifo_irq_pkg.sv
package i2c_fifo_irq_pkg;
  localparam int ST_TX_AE = 0;
  localparam int ST_RX_AF = 1;
  localparam int ST_TX_UR = 2;
  localparam int ST_TX_OR = 3;
  localparam int ST_RX_UR = 4;
  localparam int ST_RX_OR = 5;
  localparam int ST_TRAIL = 6;
  localparam int ST_XFER  = 9;

  localparam logic [31:0] ST_MASK  = 32'h0000_027F;
  localparam logic [31:0] EN_MASK  = 32'h0000_0243;
  localparam logic [31:0] ERR_MASK = 32'h0000_003C;

  localparam int RX_TRIG_LSB = 4;
  localparam int TX_TRIG_LSB = 16;

  typedef enum logic [1:0] {
    SEL_QCTL  = 2'd0,
    SEL_IEN   = 2'd1,
    SEL_ISTAT = 2'd2,
    SEL_IDLE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             pop_i,
  output logic [DW-1:0]    rdata_o,
  output logic [LVL_W-1:0] level_o,
  output logic             ovf_o,
  output logic             udf_o
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [LVL_W-1:0] lvl_q;
  logic             full, empty, do_push, do_pop;

  assign full    = (lvl_q == LVL_W'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign do_push = !flush_i && push_i && !full;
  assign do_pop  = !flush_i && pop_i && !empty;
  assign ovf_o   = !flush_i && push_i && full;
  assign udf_o   = !flush_i && pop_i && empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= wdata_i;
  end

  assign rdata_o = mem[rp_q];
  assign level_o = lvl_q;
endmodule

// File: rtl/trail_timer.sv
module trail_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] idle_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (kick_i || !arm_i)   cnt_q <= '0;
    else if (cnt_q != idle_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign fire_o = arm_i && !kick_i && (cnt_q == idle_i);
endmodule

// File: rtl/i2c_fifo_irq_unit.sv
module i2c_fifo_irq_unit
  import i2c_fifo_irq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int IDLE_W = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_sel_i,
  input  logic [31:0] wr_data_i,
  input  logic        tx_push_i,
  input  logic [7:0]  tx_data_i,
  input  logic        tx_pop_i,
  output logic [7:0]  tx_data_o,
  input  logic        rx_push_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_pop_i,
  output logic [7:0]  rx_data_o,
  input  logic        xfer_evt_i,
  output logic [31:0] int_status_o,
  output logic [31:0] queue_status_o,
  output logic        irq_o
);
  // queue index 0 = receive, 1 = transmit (matches enable bit order)
  logic [1:0]        q_en;
  logic [LVL_W-1:0]  rx_trig, tx_trig;
  logic [31:0]       ien_q, st_q, st_set, st_clr;
  logic [IDLE_W-1:0] idle_q;

  logic             q_push [2];
  logic             q_pop  [2];
  logic [7:0]       q_wd   [2];
  logic [7:0]       q_rd   [2];
  logic [LVL_W-1:0] q_lvl  [2];
  logic             q_ovf  [2];
  logic             q_udf  [2];
  logic             trail_arm, trail_fire;

  assign q_push[0] = rx_push_i;
  assign q_pop[0]  = rx_pop_i;
  assign q_wd[0]   = rx_data_i;
  assign q_push[1] = tx_push_i;
  assign q_pop[1]  = tx_pop_i;
  assign q_wd[1]   = tx_data_i;

  for (genvar q = 0; q < 2; q++) begin : g_queue
    byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (!q_en[q]),
      .push_i  (q_push[q]),
      .wdata_i (q_wd[q]),
      .pop_i   (q_pop[q]),
      .rdata_o (q_rd[q]),
      .level_o (q_lvl[q]),
      .ovf_o   (q_ovf[q]),
      .udf_o   (q_udf[q])
    );
  end

  assign rx_data_o = q_rd[0];
  assign tx_data_o = q_rd[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_en    <= '0;
      rx_trig <= '0;
      tx_trig <= '0;
      ien_q   <= '0;
      idle_q  <= '0;
    end else if (wr_en_i) begin
      case (reg_sel_e'(wr_sel_i))
        SEL_QCTL: begin
          q_en    <= wr_data_i[1:0];
          rx_trig <= wr_data_i[RX_TRIG_LSB +: LVL_W];
          tx_trig <= wr_data_i[TX_TRIG_LSB +: LVL_W];
        end
        SEL_IEN:  ien_q  <= wr_data_i & EN_MASK;
        SEL_IDLE: idle_q <= wr_data_i[IDLE_W-1:0];
        default: ;
      endcase
    end
  end

  assign trail_arm = (q_lvl[0] != '0) && (q_lvl[0] < rx_trig);

  trail_timer #(.CNT_W(IDLE_W)) u_trail (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (trail_arm),
    .kick_i (rx_push_i),
    .idle_i (idle_q),
    .fire_o (trail_fire)
  );

  always_comb begin
    st_set           = '0;
    st_set[ST_TX_AE] = q_en[1] && (q_lvl[1] <= tx_trig);
    st_set[ST_RX_AF] = q_en[0] && (q_lvl[0] >= rx_trig);
    st_set[ST_TX_UR] = q_udf[1];
    st_set[ST_TX_OR] = q_ovf[1];
    st_set[ST_RX_UR] = q_udf[0];
    st_set[ST_RX_OR] = q_ovf[0];
    st_set[ST_TRAIL] = trail_fire;
    st_set[ST_XFER]  = xfer_evt_i;
  end

  assign st_clr = (wr_en_i && reg_sel_e'(wr_sel_i) == SEL_ISTAT) ? (wr_data_i & ST_MASK) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= (st_q & ~st_clr) | st_set;
  end

  assign int_status_o = st_q;
  assign irq_o        = |(st_q & (ien_q | ERR_MASK));

  always_comb begin
    queue_status_o        = '0;
    queue_status_o[6:0]   = 7'(q_lvl[1]);
    queue_status_o[7]     = (q_lvl[1] == LVL_W'(DEPTH));
    queue_status_o[8]     = (q_lvl[1] == '0);
    queue_status_o[22:16] = 7'(q_lvl[0]);
    queue_status_o[23]    = (q_lvl[0] == LVL_W'(DEPTH));
    queue_status_o[24]    = (q_lvl[0] == '0);
  end
endmodule

// File: rtl/i2c_fifo_irq_chk.sv
module i2c_fifo_irq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  q_en_i,
  input logic        wr_en_i,
  input logic [1:0]  wr_sel_i,
  input logic [31:0] wr_data_i,
  input logic        tx_push_i,
  input logic        rx_pop_i,
  input logic        xfer_evt_i,
  input logic [31:0] int_status_i,
  input logic [31:0] queue_status_i,
  input logic        irq_i
);
  a_r2_disabled_rx_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_en_i[0] |=> queue_status_i[24]);

  a_r4_tx_empty_sets_ae: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_en_i[1] && queue_status_i[8] |=> int_status_i[0]);

  a_r6_tx_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_en_i[1] && tx_push_i && queue_status_i[7] |=> int_status_i[3]);

  a_r6_rx_underrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_en_i[0] && rx_pop_i && queue_status_i[24] |=> int_status_i[4]);

  a_r7_trail_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_status_i[6]) |-> $past(!queue_status_i[24]));

  a_r8_xfer_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_evt_i |=> int_status_i[9]);

  a_r9_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sel_i == 2'd2 && wr_data_i[9] && !xfer_evt_i |=> !int_status_i[9]);

  a_r10_error_drives_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|int_status_i[5:2]) |-> irq_i);
endmodule

bind i2c_fifo_irq_unit i2c_fifo_irq_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .q_en_i         (q_en),
  .wr_en_i        (wr_en_i),
  .wr_sel_i       (wr_sel_i),
  .wr_data_i      (wr_data_i),
  .tx_push_i      (tx_push_i),
  .rx_pop_i       (rx_pop_i),
  .xfer_evt_i     (xfer_evt_i),
  .int_status_i   (int_status_o),
  .queue_status_i (queue_status_o),
  .irq_i          (irq_o)
);

// File: tb/i2c_fifo_irq_unit_tb.sv
`timescale 1ns/1ps
module i2c_fifo_irq_unit_tb;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int TMASK = (1 << LVL_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0, xfer = 1'b0;
  logic [7:0]  tx_din = '0, rx_din = '0;
  logic [7:0]  tx_dout, rx_dout;
  logic [31:0] int_status, queue_status;
  logic        irq;

  always #2.5 clk = ~clk;

  i2c_fifo_irq_unit #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .tx_push_i(tx_push), .tx_data_i(tx_din), .tx_pop_i(tx_pop), .tx_data_o(tx_dout),
    .rx_push_i(rx_push), .rx_data_i(rx_din), .rx_pop_i(rx_pop), .rx_data_o(rx_dout),
    .xfer_evt_i(xfer), .int_status_o(int_status), .queue_status_o(queue_status), .irq_o(irq)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  logic [7:0]  txq[$], rxq[$];
  logic [31:0] m_stat, m_ien, m_qctl, ns;
  int          m_idle, m_cnt, txl, rxl, rtr, ttr;
  bit          txe, rxe, arm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      m_stat = 0; m_ien = 0; m_qctl = 0; m_idle = 0; m_cnt = 0;
    end else begin
      txl = txq.size(); rxl = rxq.size();
      txe = m_qctl[1]; rxe = m_qctl[0];
      rtr = int'((m_qctl >> 4) & TMASK);
      ttr = int'((m_qctl >> 16) & TMASK);
      arm = (rxl > 0) && (rxl < rtr);
      ns = m_stat;
      if (wr_en && wr_sel == 2'd2) ns = ns & ~(wr_data & 32'h27F);
      if (txe && txl <= ttr) ns[0] = 1'b1;
      if (rxe && rxl >= rtr) ns[1] = 1'b1;
      if (txe && tx_pop && txl == 0) ns[2] = 1'b1;
      if (txe && tx_push && txl == DEPTH) ns[3] = 1'b1;
      if (rxe && rx_pop && rxl == 0) ns[4] = 1'b1;
      if (rxe && rx_push && rxl == DEPTH) ns[5] = 1'b1;
      if (arm && !rx_push && m_cnt == m_idle) ns[6] = 1'b1;
      if (xfer) ns[9] = 1'b1;
      m_stat = ns;
      if (rx_push || !arm) m_cnt = 0;
      else if (m_cnt != m_idle) m_cnt++;
      if (!txe) txq.delete();
      else begin
        if (tx_pop && txl > 0) void'(txq.pop_front());
        if (tx_push && txl < DEPTH) txq.push_back(tx_din);
      end
      if (!rxe) rxq.delete();
      else begin
        if (rx_pop && rxl > 0) void'(rxq.pop_front());
        if (rx_push && rxl < DEPTH) rxq.push_back(rx_din);
      end
      if (wr_en) begin
        case (wr_sel)
          2'd0: m_qctl = wr_data;
          2'd1: m_ien  = wr_data & 32'h243;
          2'd3: m_idle = int'(wr_data[3:0]);
          default: ;
        endcase
      end
    end
  end

  // compare every cycle at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] eq;
      eq = 32'(txq.size()) | (32'(txq.size() == DEPTH) << 7) | (32'(txq.size() == 0) << 8)
         | (32'(rxq.size()) << 16) | (32'(rxq.size() == DEPTH) << 23) | (32'(rxq.size() == 0) << 24);
      chk("R3 queue status", queue_status, eq);
      chk("R4 almost-empty", 32'(int_status[0]), 32'(m_stat[0]));
      chk("R5 almost-full", 32'(int_status[1]), 32'(m_stat[1]));
      chk("R6 under/overrun", 32'(int_status[5:2]), 32'(m_stat[5:2]));
      chk("R7 trailing", 32'(int_status[6]), 32'(m_stat[6]));
      chk("R8 transfer event", 32'(int_status[9]), 32'(m_stat[9]));
      chk("R9 status word", int_status, m_stat);
      chk("R10 irq", 32'(irq), 32'(|(m_stat & (m_ien | 32'h3C))));
      if (txq.size() > 0) chk("R3 tx head", 32'(tx_dout), 32'(txq[0]));
      if (rxq.size() > 0) chk("R3 rx head", 32'(rx_dout), 32'(rxq[0]));
    end
  end

  task automatic tick();
    @(negedge clk);
    wr_en = 0; tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; xfer = 0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick(); tick();
    chk("R1 status", int_status, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 queue status", queue_status, 32'h0100_0100);

    // R2: disabled queues ignore traffic
    tx_push = 1; tx_din = 8'hAA; rx_push = 1; rx_din = 8'h55; tx_pop = 1; tick();
    rx_pop = 1; tick(); tick();
    chk("R2 disabled queue status", queue_status, 32'h0100_0100);
    chk("R2 no error bits", int_status, 32'h0);

    wr(2'd0, 32'h0002_0043);   // both on, rx trig 4, tx trig 2
    tick();
    chk("R4 ae after enable", 32'(int_status[0]), 32'h1);
    wr(2'd1, 32'h243);
    chk("R10 irq with ae enabled", 32'(irq), 32'h1);

    for (int i = 1; i <= 5; i++) begin tx_push = 1; tx_din = 8'(i); tick(); end
    wr(2'd2, 32'h1);
    tick();
    chk("R9 ae cleared", 32'(int_status[0]), 32'h0);
    chk("R10 irq low", 32'(irq), 32'h0);
    for (int i = 0; i < 3; i++) begin tx_pop = 1; tick(); end
    tick();
    chk("R4 ae at trigger", 32'(int_status[0]), 32'h1);
    chk("R3 tx head after pops", 32'(tx_dout), 32'h4);

    // trailing
    wr(2'd3, 32'h5);
    for (int i = 0; i < 3; i++) begin rx_push = 1; rx_din = 8'h30 + 8'(i); tick(); end
    repeat (5) tick();
    chk("R7 not yet", 32'(int_status[6]), 32'h0);
    tick();
    chk("R7 trailing fired", 32'(int_status[6]), 32'h1);
    rx_push = 1; rx_din = 8'h33; tick(); tick();
    chk("R5 af at trigger", 32'(int_status[1]), 32'h1);

    // overrun / underrun
    for (int i = 0; i < 14; i++) begin tx_push = 1; tx_din = 8'h80 + 8'(i); tick(); end
    chk("R3 tx full", queue_status[8:0], 9'h090);
    tx_push = 1; tx_din = 8'hEE; tick();
    chk("R6 tx overrun", 32'(int_status[3]), 32'h1);
    chk("R6 tx unchanged", queue_status[8:0], 9'h090);
    for (int i = 0; i < 5; i++) begin rx_pop = 1; tick(); end
    chk("R6 rx underrun", 32'(int_status[4]), 32'h1);
    for (int i = 0; i < 17; i++) begin tx_pop = 1; tick(); end
    chk("R6 tx underrun", 32'(int_status[2]), 32'h1);
    for (int i = 0; i < 17; i++) begin rx_push = 1; rx_din = 8'(i); tick(); end
    chk("R6 rx overrun", 32'(int_status[5]), 32'h1);

    // R8 / R9
    xfer = 1; wr(2'd2, 32'h200);
    chk("R9 set wins over clear", 32'(int_status[9]), 32'h1);
    wr(2'd2, 32'h200);
    chk("R9 cleared", 32'(int_status[9]), 32'h0);
    xfer = 1; tick();
    chk("R8 transfer event", 32'(int_status[9]), 32'h1);

    // R2 flush
    wr(2'd0, 32'h0); tick();
    chk("R2 flushed", queue_status, 32'h0100_0100);

    // R10 masking
    wr(2'd2, 32'h27F);
    wr(2'd1, 32'h0);
    wr(2'd0, 32'h3);
    xfer = 1; tick(); tick();
    chk("R10 masked irq low", 32'(irq), 32'h0);
    rx_pop = 1; tick();
    chk("R10 error always enabled", 32'(irq), 32'h1);
    repeat (3) tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule